// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block sits next to a small 8-bit processor core and decides, once per machine cycle, whether the core should take an interrupt. Seven sources report pending flags. Each source has its own enable bit and a 2-bit priority level, and a single global enable masks all of them. Requests are combined with the current inputs in the same cycle and are never stored. A flag that is not granted simply has to still be present the next time the core can accept a vector.

A vector is issued only on the last machine cycle of an instruction. It is withheld when that instruction writes the interrupt configuration or is a return-from-interrupt. The winning source must also have a priority strictly above the highest level already in service. When a vector is issued, the block produces a one-cycle request carrying the 16-bit entry address. In the same cycle it marks the winner's level as in service and emits a clear strobe for the flags that the hardware acknowledges on its own.

A return-from-interrupt retires the highest level in service. An ordinary subroutine return has no effect on the block.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A source requests only while its flag, its own enable bit and `glob_en` are all 1 in the evaluated cycle. Requests are not stored, so a flag that falls before a granting cycle is never vectored.
- R2: A vector is issued only for a cycle with `last_cycle`=1, `blk_write`=0 and `reti`=0. The inputs of cycle N set the registered outputs that are seen after the next clock edge, and `vec_req` lasts one cycle per grant.
- R3: With `glob_en`=0, no vector is issued, whatever the flags and enable bits are.
- R4: Source i takes its level from `src_lvl[2i+1:2i]`, where 3 is the highest level. Among requesting sources, the one with the highest level wins.
- R5: Among requesting sources at the same level, the lowest index wins. The indices are: 0 external-0, 1 timer-0, 2 external-1, 3 timer-1, 4 serial, 5 timer-2, 6 watchdog.
- R6: A vector is issued only if the winner's level is strictly above the highest bit set in `in_svc`. While `in_svc[3]` is set, nothing is vectored.
- R7: While `vec_req`=1, `vec_addr` equals 8*index+3 (0x0003, 0x000B, …, 0x0033). Otherwise `vec_addr` is 0.
- R8: `flag_clr` pulses together with `vec_req`, only at the winner's bit. Bits 1 and 3 always pulse. Bit 0 pulses only if `ext_edge[0]`=1, and bit 2 only if `ext_edge[1]`=1. Bits 4 to 6 never pulse.
- R9: `in_svc[l]` is set in the same cycle as a vector at level l. A cycle with `reti`=1 and `last_cycle`=1 clears the highest set bit, or does nothing when no bit is set. No other input clears a bit.
- R10: While `rst` is high, and after it is released, `vec_req`, `vec_addr`, `flag_clr` and `in_svc` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | 7 | Pending flag of each source |
| src_en | input | 7 | Per-source enable |
| glob_en | input | 1 | Global enable |
| src_lvl | input | 14 | 2-bit priority level per source |
| ext_edge | input | 2 | External inputs 0/1 configured edge-triggered |
| last_cycle | input | 1 | Current cycle is the instruction's final one |
| blk_write | input | 1 | Current instruction writes interrupt configuration |
| reti | input | 1 | Current instruction is a return-from-interrupt |
| vec_req | output | 1 | One-cycle hardware-call request |
| vec_addr | output | 16 | Entry address for the call |
| flag_clr | output | 7 | Per-source hardware flag clear strobe |
| in_svc | output | 4 | Priority levels currently in service |

## Verification
Two functions can meet in a single cycle: a return-from-interrupt that retires a level, and a higher-priority request that arrives on that same final instruction cycle. The bench drives a pending request together with `reti` and `last_cycle`, both in random traffic and in a directed case. It then checks that `in_svc` loses its top bit while no vector is issued. On the next open cycle, the request must be granted against the reduced in-service state. A reference model in the bench computes the expected grant, address, strobes and in-service bits for every cycle.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_SRC = 7;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int SRC_W   = $clog2(NUM_SRC);
    localparam int ADDR_W  = 16;
    localparam int EXT_NUM = 2;
    localparam int LVLS_W  = NUM_SRC * LVL_W;

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4,
        SRC_TMR2 = 3'd5,
        SRC_WDOG = 3'd6
    } src_e;

    typedef enum logic [1:0] {
        CLR_NEVER,
        CLR_ALWAYS,
        CLR_IF_EDGE
    } clr_mode_e;

    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] idx;
        logic [LVL_W-1:0] lvl;
    } grant_t;

    typedef struct packed {
        logic             valid;
        logic [LVL_W-1:0] lvl;
    } svc_lvl_t;

    function automatic logic [LVL_W-1:0] lvl_of(input logic [LVLS_W-1:0] flat, input int i);
        return flat[i*LVL_W +: LVL_W];
    endfunction

    function automatic logic [ADDR_W-1:0] vec_of(input logic [SRC_W-1:0] idx);
        return ADDR_W'({idx, 3'b011});
    endfunction

    function automatic clr_mode_e clr_mode_of(input src_e s);
        case (s)
            SRC_TMR0, SRC_TMR1: return CLR_ALWAYS;
            SRC_EXT0, SRC_EXT1: return CLR_IF_EDGE;
            default:            return CLR_NEVER;
        endcase
    endfunction

    function automatic int edge_sel(input src_e s);
        return (s == SRC_EXT1) ? 1 : 0;
    endfunction

    function automatic svc_lvl_t top_of(input logic [NUM_LVL-1:0] v);
        svc_lvl_t r;
        r = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (v[l]) begin
                r.valid = 1'b1;
                r.lvl   = LVL_W'(l);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_req_gate.sv
module irq_req_gate
    import irq_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0] flag,
    input  logic [NUM_SRC-1:0] en,
    input  logic               glob_en,
    output logic [NUM_SRC-1:0] req
);

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_gate
            assign req[i] = flag[i] & en[i] & glob_en;
        end
    endgenerate

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_prio_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic [LVLS_W-1:0]  lvl_flat,
    output grant_t             grant
);

    logic [NUM_LVL-1:0][NUM_SRC-1:0] at_lvl;

    genvar l, i;
    generate
        for (l = 0; l < NUM_LVL; l++) begin : g_lvl
            for (i = 0; i < NUM_SRC; i++) begin : g_src
                assign at_lvl[l][i] = req[i] && (lvl_of(lvl_flat, i) == LVL_W'(l));
            end
        end
    endgenerate

    always_comb begin
        grant = '0;
        for (int lv = 0; lv < NUM_LVL; lv++) begin
            if (|at_lvl[lv]) begin
                grant.valid = 1'b1;
                grant.lvl   = LVL_W'(lv);
                for (int s = NUM_SRC - 1; s >= 0; s--) begin
                    if (at_lvl[lv][s]) begin
                        grant.idx = SRC_W'(s);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/irq_svc_stack.sv
module irq_svc_stack
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               push,
    input  logic [LVL_W-1:0]   push_lvl,
    input  logic               pop,
    output logic [NUM_LVL-1:0] svc_bits,
    output svc_lvl_t           cur
);

    logic [NUM_LVL-1:0] pop_mask;
    logic [NUM_LVL-1:0] push_mask;

    assign cur = top_of(svc_bits);

    always_comb begin
        pop_mask  = '0;
        push_mask = '0;
        if (pop && cur.valid) begin
            pop_mask[cur.lvl] = 1'b1;
        end
        if (push) begin
            push_mask[push_lvl] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_bits <= '0;
        end else begin
            svc_bits <= (svc_bits & ~pop_mask) | push_mask;
        end
    end

endmodule

// File: rtl/irq_flag_clr.sv
module irq_flag_clr
    import irq_prio_pkg::*;
(
    input  logic               fire,
    input  logic [SRC_W-1:0]   idx,
    input  logic [EXT_NUM-1:0] ext_edge,
    output logic [NUM_SRC-1:0] clr
);

    genvar i;
    generate
        for (i = 0; i < NUM_SRC; i++) begin : g_clr
            if (clr_mode_of(src_e'(i)) == CLR_ALWAYS) begin : g_always
                assign clr[i] = fire && (idx == SRC_W'(i));
            end else if (clr_mode_of(src_e'(i)) == CLR_IF_EDGE) begin : g_edge
                assign clr[i] = fire && (idx == SRC_W'(i)) && ext_edge[edge_sel(src_e'(i))];
            end else begin : g_never
                assign clr[i] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_flag,
    input  logic [NUM_SRC-1:0]  src_en,
    input  logic                glob_en,
    input  logic [LVLS_W-1:0]   src_lvl,
    input  logic [EXT_NUM-1:0]  ext_edge,
    input  logic                last_cycle,
    input  logic                blk_write,
    input  logic                reti,
    output logic                vec_req,
    output logic [ADDR_W-1:0]   vec_addr,
    output logic [NUM_SRC-1:0]  flag_clr,
    output logic [NUM_LVL-1:0]  in_svc
);

    logic [NUM_SRC-1:0] req;
    grant_t             grant;
    svc_lvl_t           cur;
    logic               window_open;
    logic               beats_cur;
    logic               fire;
    logic               pop;
    logic [NUM_SRC-1:0] clr_next;

    irq_req_gate u_gate (
        .flag    (src_flag),
        .en      (src_en),
        .glob_en (glob_en),
        .req     (req)
    );

    irq_arbiter u_arb (
        .req      (req),
        .lvl_flat (src_lvl),
        .grant    (grant)
    );

    assign window_open = last_cycle && !blk_write && !reti;
    assign beats_cur   = !cur.valid || (grant.lvl > cur.lvl);
    assign fire        = grant.valid && window_open && beats_cur;
    assign pop         = reti && last_cycle;

    irq_svc_stack u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (fire),
        .push_lvl (grant.lvl),
        .pop      (pop),
        .svc_bits (in_svc),
        .cur      (cur)
    );

    irq_flag_clr u_clr (
        .fire     (fire),
        .idx      (grant.idx),
        .ext_edge (ext_edge),
        .clr      (clr_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_req  <= 1'b0;
            vec_addr <= '0;
            flag_clr <= '0;
        end else begin
            vec_req  <= fire;
            vec_addr <= fire ? vec_of(grant.idx) : '0;
            flag_clr <= clr_next;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk
    import irq_prio_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               glob_en,
    input logic               last_cycle,
    input logic               blk_write,
    input logic               reti,
    input logic               vec_req,
    input logic [ADDR_W-1:0]  vec_addr,
    input logic [NUM_SRC-1:0] flag_clr,
    input logic [NUM_LVL-1:0] in_svc
);

    AST_VEC_WINDOW: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> $past(last_cycle && !blk_write && !reti)); // R2

    AST_GLOBAL_MASK: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> !vec_req); // R3

    AST_NEST_GROW: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> ($countones(in_svc) == $countones($past(in_svc)) + 1)); // R6

    AST_TOP_LOCK: assert property (@(posedge clk) disable iff (rst)
        in_svc[NUM_LVL-1] |=> !vec_req); // R6

    AST_ADDR_IDLE: assert property (@(posedge clk) disable iff (rst)
        !vec_req |-> (vec_addr == '0)); // R7

    AST_CLR_WITH_VEC: assert property (@(posedge clk) disable iff (rst)
        (|flag_clr) |-> vec_req); // R8

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(flag_clr)); // R8

    AST_CLR_SOFT_ONLY: assert property (@(posedge clk) disable iff (rst)
        flag_clr[NUM_SRC-1:4] == '0); // R8

    AST_RETI_POP: assert property (@(posedge clk) disable iff (rst)
        (reti && last_cycle && (|in_svc)) |=> ($countones(in_svc) == $countones($past(in_svc)) - 1)); // R9

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .glob_en    (glob_en),
    .last_cycle (last_cycle),
    .blk_write  (blk_write),
    .reti       (reti),
    .vec_req    (vec_req),
    .vec_addr   (vec_addr),
    .flag_clr   (flag_clr),
    .in_svc     (in_svc)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  src_flag = '0;
    logic [6:0]  src_en = '0;
    logic        glob_en = 1'b0;
    logic [13:0] src_lvl = '0;
    logic [1:0]  ext_edge = '0;
    logic        last_cycle = 1'b0;
    logic        blk_write = 1'b0;
    logic        reti = 1'b0;
    logic        vec_req;
    logic [15:0] vec_addr;
    logic [6:0]  flag_clr;
    logic [3:0]  in_svc;

    int n_chk = 0;
    int n_err = 0;

    logic [3:0]  m_svc = '0;
    logic        e_req;
    logic [15:0] e_addr;
    logic [6:0]  e_clr;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst(rst), .src_flag(src_flag), .src_en(src_en),
        .glob_en(glob_en), .src_lvl(src_lvl), .ext_edge(ext_edge),
        .last_cycle(last_cycle), .blk_write(blk_write), .reti(reti),
        .vec_req(vec_req), .vec_addr(vec_addr), .flag_clr(flag_clr),
        .in_svc(in_svc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int top_lvl(input logic [3:0] v);
        int r = -1;
        for (int l = 0; l < 4; l++) if (v[l]) r = l;
        return r;
    endfunction

    // Reference model: one evaluated cycle from the current inputs
    task automatic model_cycle();
        int best = -1;
        int bl = -1;
        int cur;
        logic fire;
        for (int i = 0; i < 7; i++) begin
            if (src_flag[i] && src_en[i] && glob_en) begin
                int l = int'(src_lvl[2*i +: 2]);
                if (l > bl) begin bl = l; best = i; end
            end
        end
        cur  = top_lvl(m_svc);
        fire = (best >= 0) && last_cycle && !blk_write && !reti && (bl > cur);
        e_req  = fire;
        e_addr = fire ? 16'(best * 8 + 3) : 16'h0;
        e_clr  = '0;
        if (fire) begin
            if (best == 1 || best == 3) e_clr[best] = 1'b1;
            if (best == 0 && ext_edge[0]) e_clr[0] = 1'b1;
            if (best == 2 && ext_edge[1]) e_clr[2] = 1'b1;
        end
        if (reti && last_cycle && cur >= 0) m_svc[cur] = 1'b0;
        if (fire) m_svc[bl] = 1'b1;
    endtask

    // Inputs are already set (at a falling edge); run one clock and compare
    task automatic run_cycle();
        model_cycle();
        @(negedge clk);
        chk("R2 vec_req", 32'(vec_req), 32'(e_req));
        chk("R7 vec_addr", 32'(vec_addr), 32'(e_addr));
        chk("R8 flag_clr", 32'(flag_clr), 32'(e_clr));
        chk("R9 in_svc", 32'(in_svc), 32'(m_svc));
    endtask

    task automatic idle_inputs();
        src_flag = '0; src_en = 7'h7F; glob_en = 1'b1; src_lvl = '0;
        ext_edge = '0; last_cycle = 1'b0; blk_write = 1'b0; reti = 1'b0;
    endtask

    task automatic drain();
        idle_inputs();
        reti = 1'b1; last_cycle = 1'b1;
        repeat (4) run_cycle();
        idle_inputs();
    endtask

    task automatic set_lvl(input int src, input int lvl);
        src_lvl[2*src +: 2] = 2'(lvl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        src_flag = 7'h7F; src_en = 7'h7F; glob_en = 1'b1; last_cycle = 1'b1;
        repeat (3) @(negedge clk);
        // R10: outputs stay cleared under reset despite active requests
        chk("R10 reset vec_req", 32'(vec_req), 0);
        chk("R10 reset vec_addr", 32'(vec_addr), 0);
        chk("R10 reset flag_clr", 32'(flag_clr), 0);
        chk("R10 reset in_svc", 32'(in_svc), 0);
        idle_inputs();
        rst = 1'b0;
        run_cycle();

        // R5: same level tie, external-0 beats serial
        src_flag = 7'b0010001; set_lvl(0, 1); set_lvl(4, 1); last_cycle = 1'b1;
        run_cycle();
        chk("R5 tie winner addr", 32'(vec_addr), 32'h0003);
        drain();

        // R4: higher level wins over lower index
        src_flag = 7'b0010001; set_lvl(0, 0); set_lvl(4, 3); last_cycle = 1'b1;
        run_cycle();
        chk("R4 level winner addr", 32'(vec_addr), 32'h0023);
        drain();

        // R6: equal level blocked while in service, higher level nests
        src_flag = 7'b0000010; set_lvl(1, 2); last_cycle = 1'b1;
        run_cycle();
        src_flag = 7'b0000100; set_lvl(2, 2);
        run_cycle();
        chk("R6 equal level blocked", 32'(vec_req), 0);
        set_lvl(2, 3);
        run_cycle();
        chk("R6 higher level nests", 32'(vec_addr), 32'h0013);
        src_flag = 7'b1000000; set_lvl(6, 3);
        run_cycle();
        chk("R6 top level locked", 32'(vec_req), 0);

        // R9: plain return keeps state; reti pops while a request is denied
        src_flag = '0; last_cycle = 1'b1;
        run_cycle();
        chk("R9 plain return keeps in_svc", 32'(in_svc), 32'b1100);
        src_flag = 7'b1000000; set_lvl(6, 3); reti = 1'b1;
        run_cycle();
        chk("R9 reti pops, R2 vector withheld", 32'({vec_req, in_svc}), 32'b00100);
        reti = 1'b0;
        run_cycle();
        chk("R2 grant after pop", 32'(vec_addr), 32'h0033);
        drain();

        // R1: request seen off the window then dropped is forgotten
        src_flag = 7'b0001000; set_lvl(3, 1); last_cycle = 1'b0;
        run_cycle();
        src_flag = '0; last_cycle = 1'b1;
        run_cycle();
        chk("R1 denied request forgotten", 32'(vec_req), 0);
        src_flag = 7'b0001000; src_en = 7'b1110111;
        run_cycle();
        chk("R1 source enable masks", 32'(vec_req), 0);
        src_en = 7'h7F;

        // R3: global enable masks everything
        src_flag = 7'h7F; glob_en = 1'b0;
        run_cycle();
        chk("R3 global mask", 32'(vec_req), 0);
        glob_en = 1'b1;

        // R2: configuration write blocks vectoring
        blk_write = 1'b1;
        run_cycle();
        chk("R2 write blocks", 32'(vec_req), 0);
        blk_write = 1'b0;
        idle_inputs();

        // R8: external-0 cleared only when edge-triggered; serial never
        src_flag = 7'b0000001; last_cycle = 1'b1; ext_edge = 2'b00;
        run_cycle();
        chk("R8 level ext no clear", 32'(flag_clr), 0);
        drain();
        src_flag = 7'b0000001; last_cycle = 1'b1; ext_edge = 2'b01;
        run_cycle();
        chk("R8 edge ext clears", 32'(flag_clr), 32'b0000001);
        drain();
        src_flag = 7'b0010000; last_cycle = 1'b1;
        run_cycle();
        chk("R8 serial not cleared", 32'({vec_req, flag_clr}), 32'b10000000);
        drain();

        // Random traffic checked against the model (R1..R9)
        for (int n = 0; n < 4000; n++) begin
            src_flag   = 7'($urandom) & 7'($urandom);
            src_en     = 7'($urandom) | 7'($urandom);
            glob_en    = ($urandom % 10) != 0;
            src_lvl    = 14'($urandom);
            ext_edge   = 2'($urandom);
            last_cycle = ($urandom % 2) != 0;
            blk_write  = ($urandom % 10) == 0;
            reti       = ($urandom % 6) == 0;
            run_cycle();
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule